// File: doc/BRIEF.md
# Center-Aligned Up/Down Timer with Buffered Update

This block is a timer counter that sweeps in both directions. It climbs from zero to a programmable limit, falls back to zero, and repeats. A programmable prescaler sets how many enabled clock cycles pass between counter steps. Both the prescaler setting and the limit are held in two stages. Software writes a staging copy. The working copy takes the staged value only when an update event occurs, so a running sweep never sees a half-applied setting.

An update event occurs each time the counter turns around, which is on reaching the limit while climbing and on reaching zero while falling. Software can also force an update with a strobe. A forced update restarts the sweep from zero, climbing. Each update produces a one-cycle pulse and can set a sticky flag that software clears. A select input decides whether forced updates raise that flag. Turnaround updates always raise it.

Top module: `centerTimer`

## Requirements
- R1: After reset the counter reads 0 and climbs, the update pulse and flag are low, the working prescaler is 0 (step on every enabled cycle), and the working limit equals the parameter ARR_INIT.
- R2: On each step the counter moves by one. It climbs until it equals the working limit, then falls until it equals 0, then climbs again. With limit 6, starting from 0, it reads 1,2,3,4,5,6,5,4,3,2,1,0,1,...
- R3: A step that lands on the limit while climbing, or on 0 while falling, reverses the direction and makes updEvent high for exactly the cycle in which cntValue shows that value. cntDown is 1 while falling.
- R4: With working prescaler P, the counter steps once every P+1 cycles in which cntEn is high. The prescaler phase returns to zero on every update event, so the first step after an update comes P+1 enabled cycles later.
- R5: Writes to the prescaler or limit staging copies do not change counting until the next update event. At each update event, both working copies load from their staging copies, and the period that starts at that update already uses the new limit.
- R6: A swUpdate strobe makes updEvent high on the next cycle, with cntValue 0 and cntDown 0, whatever cntEn is.
- R7: A turnaround update always sets updFlag. A swUpdate sets updFlag only when updReqSel is 0. When updReqSel is 1, a swUpdate leaves the flag unchanged.
- R8: updFlag stays set until a flagClr strobe. If an update that sets the flag and a flagClr fall in the same cycle, the flag ends up set.
- R9: While cntEn is low, the counter and the prescaler phase hold their values and no turnaround update occurs.
- R10: While the working limit is 0, the counter stays at 0 and no turnaround update occurs.
- R11: A staging write made in the same cycle as an update event is not used by that update. The update loads the previous staged value, and the new value is applied at the following update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cntEn | input | 1 | Counter enable |
| pscWrEn | input | 1 | Write strobe for the prescaler staging copy |
| pscWrData | input | PSC_W | Prescaler value to stage |
| arrWrEn | input | 1 | Write strobe for the limit staging copy |
| arrWrData | input | CNT_W | Limit value to stage |
| swUpdate | input | 1 | Software strobe that forces an update event |
| updReqSel | input | 1 | When 1, a forced update does not set the flag |
| flagClr | input | 1 | Clears the update flag |
| cntValue | output | CNT_W | Current counter value |
| cntDown | output | 1 | 1 while the counter is falling |
| updEvent | output | 1 | One-cycle update event pulse |
| updFlag | output | 1 | Sticky update flag |

## Verification
Several functions can land in the same cycle. A forced update can arrive on the very edge where the counter would turn around. A flag clear can meet a flag-setting update. A staging write can coincide with the update that would consume it. The bench provokes these cases in two ways: it pulses swUpdate together with flagClr and with staging writes, and it runs a long mixed phase with random strobes against small limits and prescalers, where forced updates often collide with turnarounds. A behavioural reference model, evaluated every clock, decides the resulting counter, direction, pulse and flag. A mismatch in any of these is reported under the requirement that the current phase is exercising.

// File: rtl/centerTimerPkg.sv
package centerTimerPkg;
  // Strobes from the update control to the counting datapath
  typedef struct packed {
    logic tick;    // prescaler wrapped: counter may step
    logic reload;  // update event: load working limit from staging
    logic init;    // forced update: restart counter at 0, climbing
  } tmrStrobe_t;
endpackage

// File: rtl/tmrCountPath.sv
module tmrCountPath
  import centerTimerPkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] ARR_INIT = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strb,
  input  logic             arrWrEn,
  input  logic [CNT_W-1:0] arrWrData,
  output logic [CNT_W-1:0] cntValue,
  output logic             cntDown,
  output logic             turnEvt
);
  localparam logic [CNT_W:0]   ONE_EXT = (CNT_W+1)'(1);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] arrPre, arrAct, cnt;
  logic             down;
  logic             stepOk, hitTop, hitBot;

  always_comb begin
    stepOk  = strb.tick && (arrAct != '0);
    hitTop  = !down && (({1'b0, cnt} + ONE_EXT) >= {1'b0, arrAct});
    hitBot  = down && (cnt <= ONE);
    turnEvt = stepOk && (hitTop || hitBot);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arrPre <= ARR_INIT;
      arrAct <= ARR_INIT;
      cnt    <= '0;
      down   <= 1'b0;
    end else begin
      if (arrWrEn) arrPre <= arrWrData;
      if (strb.reload) arrAct <= arrPre;
      if (strb.init) begin
        cnt  <= '0;
        down <= 1'b0;
      end else if (stepOk) begin
        cnt <= down ? cnt - ONE : cnt + ONE;
        if (hitTop || hitBot) down <= !down;
      end
    end
  end

  assign cntValue = cnt;
  assign cntDown  = down;
endmodule

// File: rtl/tmrUpdateCtrl.sv
module tmrUpdateCtrl
  import centerTimerPkg::*;
#(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  logic             pscWrEn,
  input  logic [PSC_W-1:0] pscWrData,
  input  logic             swUpdate,
  input  logic             updReqSel,
  input  logic             flagClr,
  input  logic             turnEvt,
  output tmrStrobe_t       strb,
  output logic             updEvent,
  output logic             updFlag
);
  localparam logic [PSC_W-1:0] ONE = PSC_W'(1);

  logic [PSC_W-1:0] pscPre, pscAct, pscCnt;
  logic             pscWrap, updNow, flagSet;

  always_comb begin
    pscWrap     = (pscCnt == pscAct);
    updNow      = turnEvt || swUpdate;
    flagSet     = turnEvt || (swUpdate && !updReqSel);
    strb.tick   = cntEn && pscWrap;
    strb.reload = updNow;
    strb.init   = swUpdate;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscPre   <= '0;
      pscAct   <= '0;
      pscCnt   <= '0;
      updEvent <= 1'b0;
      updFlag  <= 1'b0;
    end else begin
      if (pscWrEn) pscPre <= pscWrData;
      if (updNow) begin
        pscAct <= pscPre;
        pscCnt <= '0;
      end else if (cntEn) begin
        pscCnt <= pscWrap ? '0 : pscCnt + ONE;
      end
      updEvent <= updNow;
      if (flagSet)      updFlag <= 1'b1;
      else if (flagClr) updFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/centerTimer.sv
module centerTimer
  import centerTimerPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter logic [CNT_W-1:0] ARR_INIT = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  logic             pscWrEn,
  input  logic [PSC_W-1:0] pscWrData,
  input  logic             arrWrEn,
  input  logic [CNT_W-1:0] arrWrData,
  input  logic             swUpdate,
  input  logic             updReqSel,
  input  logic             flagClr,
  output logic [CNT_W-1:0] cntValue,
  output logic             cntDown,
  output logic             updEvent,
  output logic             updFlag
);
  tmrStrobe_t strb;
  logic       turnEvt;

  tmrUpdateCtrl #(.PSC_W(PSC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cntEn(cntEn),
    .pscWrEn(pscWrEn), .pscWrData(pscWrData),
    .swUpdate(swUpdate), .updReqSel(updReqSel), .flagClr(flagClr),
    .turnEvt(turnEvt), .strb(strb),
    .updEvent(updEvent), .updFlag(updFlag)
  );

  tmrCountPath #(.CNT_W(CNT_W), .ARR_INIT(ARR_INIT)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb),
    .arrWrEn(arrWrEn), .arrWrData(arrWrData),
    .cntValue(cntValue), .cntDown(cntDown), .turnEvt(turnEvt)
  );
endmodule

// File: rtl/centerTimerChk.sv
module centerTimerChk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntEn,
  input logic             swUpdate,
  input logic             updReqSel,
  input logic             flagClr,
  input logic [CNT_W-1:0] cntValue,
  input logic             cntDown,
  input logic             updEvent,
  input logic             updFlag
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(swUpdate) && cntValue != $past(cntValue)) |->
      ((cntValue - $past(cntValue)) == ONE || ($past(cntValue) - cntValue) == ONE)); // R2
  AST_ZERO_TURN: assert property (@(posedge clk) disable iff (!rstN)
    (updEvent && !$past(swUpdate) && cntValue == '0) |-> !cntDown); // R3
  AST_SW_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    swUpdate |=> (updEvent && cntValue == '0 && !cntDown)); // R6
  AST_FLAG_ON_TURN: assert property (@(posedge clk) disable iff (!rstN)
    (updEvent && !$past(swUpdate)) |-> updFlag); // R7
  AST_FLAG_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (swUpdate && updReqSel && !cntEn && !updFlag) |=> !updFlag); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (updFlag && !flagClr) |=> updFlag); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && swUpdate && !updReqSel) |=> updFlag); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEn && !swUpdate) |=> ($stable(cntValue) && !updEvent)); // R9
endmodule

bind centerTimer centerTimerChk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cntEn(cntEn), .swUpdate(swUpdate),
  .updReqSel(updReqSel), .flagClr(flagClr), .cntValue(cntValue),
  .cntDown(cntDown), .updEvent(updEvent), .updFlag(updFlag)
);

// File: tb/centerTimer_tb.sv
`timescale 1ns/1ps
module centerTimer_tb;
  localparam int CNT_W = 16;
  localparam int PSC_W = 16;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntEn = 0, pscWrEn = 0, arrWrEn = 0, swUpdate = 0, updReqSel = 0, flagClr = 0;
  logic [PSC_W-1:0] pscWrData = '0;
  logic [CNT_W-1:0] arrWrData = '0;
  logic [CNT_W-1:0] cntValue;
  logic cntDown, updEvent, updFlag;

  always #2 clk = ~clk;

  centerTimer #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_dut (
    .clk(clk), .rstN(rstN), .cntEn(cntEn),
    .pscWrEn(pscWrEn), .pscWrData(pscWrData),
    .arrWrEn(arrWrEn), .arrWrData(arrWrData),
    .swUpdate(swUpdate), .updReqSel(updReqSel), .flagClr(flagClr),
    .cntValue(cntValue), .cntDown(cntDown),
    .updEvent(updEvent), .updFlag(updFlag)
  );

  // Behavioural reference: plain integers, next state from the requirements
  integer mCnt = 0, mDown = 0, mPh = 0, mPsc = 0, mPscStage = 0;
  integer mLim = MAXC, mLimStage = MAXC, mEvt = 0, mFlag = 0;
  integer nVec = 0, nBad = 0;
  string  curReq = "R1";
  bit     done = 0;

  always @(posedge clk) begin
    integer turned, upd, nc, nd;
    if (!rstN) begin
      mCnt = 0; mDown = 0; mPh = 0; mPsc = 0; mPscStage = 0;
      mLim = MAXC; mLimStage = MAXC; mEvt = 0; mFlag = 0;
    end else begin
      turned = 0; nc = mCnt; nd = mDown;
      if (cntEn && mPh == mPsc && mLim != 0) begin
        if (mDown == 0) begin
          nc = mCnt + 1;
          if (nc >= mLim) begin turned = 1; nd = 1; end
        end else begin
          nc = mCnt - 1;
          if (nc <= 0) begin turned = 1; nd = 0; end
        end
      end
      upd = (turned != 0 || swUpdate) ? 1 : 0;
      if (swUpdate) begin nc = 0; nd = 0; end
      if (upd != 0) mPh = 0;
      else if (cntEn) mPh = (mPh == mPsc) ? 0 : mPh + 1;
      if (upd != 0) begin mPsc = mPscStage; mLim = mLimStage; end
      if (pscWrEn) mPscStage = int'(pscWrData);
      if (arrWrEn) mLimStage = int'(arrWrData);
      if (turned != 0 || (swUpdate && !updReqSel)) mFlag = 1;
      else if (flagClr) mFlag = 0;
      mEvt = upd; mCnt = nc; mDown = nd;
    end
  end

  task automatic compare();
    nVec++;
    if (int'(cntValue) != mCnt) begin
      nBad++; $display("FAIL %s cntValue act=%0d exp=%0d t=%0t", curReq, cntValue, mCnt, $time);
    end
    if (int'(cntDown) != mDown) begin
      nBad++; $display("FAIL %s cntDown act=%0d exp=%0d t=%0t", curReq, cntDown, mDown, $time);
    end
    if (int'(updEvent) != mEvt) begin
      nBad++; $display("FAIL %s updEvent act=%0d exp=%0d t=%0t", curReq, updEvent, mEvt, $time);
    end
    if (int'(updFlag) != mFlag) begin
      nBad++; $display("FAIL %s updFlag act=%0d exp=%0d t=%0t", curReq, updFlag, mFlag, $time);
    end
  endtask

  // One clock: inputs are already driven; compare at the falling edge, then drop strobes
  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare();
      pscWrEn = 0; arrWrEn = 0; swUpdate = 0; flagClr = 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R1"; compare(); step(4);                     // reset state holds
    curReq = "R5"; arrWrEn = 1; arrWrData = 6; step(3);    // staged only
    curReq = "R2"; swUpdate = 1; step(1);                  // R7: flag sets, sel=0
    cntEn = 1; step(30);
    curReq = "R3"; flagClr = 1; step(20);
    curReq = "R4"; pscWrEn = 1; pscWrData = 1; swUpdate = 1; step(1); step(30);
    pscWrEn = 1; pscWrData = 2; step(1); step(40);
    curReq = "R5"; arrWrEn = 1; arrWrData = 3; step(1); step(40);
    curReq = "R11"; swUpdate = 1; arrWrEn = 1; arrWrData = 9; step(1); step(30);
    swUpdate = 1; step(1); step(25);
    curReq = "R9"; step(5); cntEn = 0; step(12); cntEn = 1; step(5);
    curReq = "R6"; cntEn = 0; swUpdate = 1; step(1); step(4);
    curReq = "R7"; updReqSel = 1; flagClr = 1; step(1); swUpdate = 1; step(1); step(3);
    updReqSel = 0;
    curReq = "R8"; flagClr = 1; swUpdate = 1; step(1); step(3); flagClr = 1; step(1); step(2);
    curReq = "R10"; cntEn = 1; arrWrEn = 1; arrWrData = 0; pscWrEn = 1; pscWrData = 0; step(1);
    swUpdate = 1; step(1); step(15);
    arrWrEn = 1; arrWrData = 5; swUpdate = 1; step(1); step(20);
    curReq = "R2";
    for (int k = 0; k < 600; k++) begin
      cntEn     = ($urandom_range(0, 9) != 0);
      swUpdate  = ($urandom_range(0, 30) == 0);
      flagClr   = ($urandom_range(0, 6) == 0);
      updReqSel = $urandom_range(0, 1);
      arrWrEn   = ($urandom_range(0, 12) == 0);
      arrWrData = CNT_W'($urandom_range(0, 12));
      pscWrEn   = ($urandom_range(0, 15) == 0);
      pscWrData = PSC_W'($urandom_range(0, 3));
      step(1);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule